// File: doc/BRIEF.md
# PC Card Bus Cycle Sequencer

This block runs one memory or I/O cycle on a PC card slot for a single channel of an external bus controller. A requester presents a 26-bit byte address, whether the access targets memory or I/O space, and whether it reads or writes. The block takes a snapshot of the channel's timing configuration and then works through a fixed sequence. First it presents the six upper address bits on the low pins of a 20-bit external address bus and pulses an upper-address latch enable. It then drives the full low address through a programmable setup period. Next it asserts exactly one active-low strobe for a programmable extension count. After that it can wait on the selected slot's active-low wait input, and finally it keeps the address through a programmable hold period.

The card address is always a byte address, for an 8-bit bus and for a 16-bit bus. Any other bus-size setting is refused: the request completes at once with an error and the card sees no activity. The wait input is brought into the clock domain through two flops. It is only looked at once the strobe-extension count has run out, so a wait signal that is not yet valid early in the strobe cannot end the cycle too soon. The data path is a plain pass-through. Write data is held on the card data output, and read data is captured on the last strobe cycle and returned with the completion pulse.

Top module: `pccard_cycle_seq`

## Requirements
- R1: After reset all four strobes and every slot select are high, the latch enable, done and data-output enable are low, and the block reports ready.
- R2: A request is taken only while ready is high. A request raised while a cycle is in progress is ignored and does not start a cycle after the current one completes.
- R3: The first cycle after acceptance is a single-cycle latch-enable phase. The latch enable is high, the external address carries request address bits 25:20 on its bits 5:0 with zeros above, and all strobes are high.
- R4: From setup through hold, the external address equals request address bits 19:0, unshifted, for both bus-size codes 2'b00 (8-bit) and 2'b01 (16-bit).
- R5: A bus-size code of 2'b10 or 2'b11 is illegal. The request is accepted and done pulses with the error flag one cycle later, with no latch enable, no strobe and no slot select.
- R6: Setup lasts setup-count + 1 cycles, with the address driven and all strobes high.
- R7: With ready mode off, the strobe stays low for extension-count + 1 cycles, and the wait inputs have no effect.
- R8: Memory reads drive OE low, memory writes drive WE low, I/O reads drive the I/O-read strobe low and I/O writes drive the I/O-write strobe low. At most one strobe is low at any time.
- R9: Hold lasts hold-count + 1 cycles with all strobes high. It is followed by a one-cycle done pulse, after which ready returns.
- R10: With ready mode on and the extension count run out, the strobe stays low while the selected slot's wait input is low. It rises on the third rising clock edge after that input goes high.
- R11: The wait input is not sampled while the extension count runs. With ready mode on and the wait input inactive, the strobe is low for extension-count + 2 cycles.
- R12: Only the selected slot's wait input is used. That slot's select output is low from the latch-enable phase through hold, and the other slot's select stays high.
- R13: Write data appears on the card data output with its enable high from setup through hold. Read data present on the card data input in the last strobe cycle is returned on the response data output while done is high.
- R14: Configuration is captured at acceptance. Changing any configuration input during a cycle does not alter that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-speed clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_addr | input | 26 | Card byte address |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| cfg_bus_size | input | 2 | 00 = 8-bit, 01 = 16-bit, others illegal |
| cfg_setup | input | 4 | Setup count |
| cfg_ext | input | 4 | Strobe extension count |
| cfg_hold | input | 4 | Hold count |
| cfg_rdy_en | input | 1 | Ready mode: honour the wait input |
| cfg_slot | input | 1 | Slot selected for the cycle |
| card_wait_n | input | 2 | Per-slot active-low wait, asynchronous |
| card_din | input | 16 | Read data from the card |
| req_ready | output | 1 | Block is idle and can take a request |
| done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | With done: illegal bus size |
| rsp_rdata | output | 16 | Read data captured from the card |
| ext_addr | output | 20 | External address pins |
| uae | output | 1 | Upper-address latch enable |
| card_sel_n | output | 2 | Per-slot active-low select |
| oe_n | output | 1 | Memory read strobe |
| we_n | output | 1 | Memory write strobe |
| iord_n | output | 1 | I/O read strobe |
| iowr_n | output | 1 | I/O write strobe |
| card_dout | output | 16 | Write data to the card |
| card_dout_en | output | 1 | Card data output enable |

## Verification
A sequencer stuck in or skipping a phase shows up at the pins within one cycle. The latch enable, the strobe or done may fail to appear, appear twice, or last one cycle longer or shorter than its programmed count. The bench measures each phase length from the pins. A wrong phase decode shows immediately as the wrong strobe, an upper-address value outside the latch-enable cycle, or a slot select that drops without a cycle. A fault in the wait path or its blanking changes the strobe length by a whole number of cycles, measured against the edge on which the wait input was released.

// File: rtl/pccard_seq_pkg.sv
package pccard_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_UPPER   = 3'd1,
        ST_SETUP   = 3'd2,
        ST_STROBE  = 3'd3,
        ST_WAITRDY = 3'd4,
        ST_HOLD    = 3'd5,
        ST_DONE    = 3'd6
    } seq_state_e;

    localparam logic [1:0] BUS_8  = 2'b00;
    localparam logic [1:0] BUS_16 = 2'b01;

endpackage

// File: rtl/pccard_phase_timer.sv
module pccard_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    // R6: a fresh load never reads as already expired unless the value was zero
    a_r6_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/pccard_wait_sync.sv
module pccard_wait_sync #(
    parameter int SLOTS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] wait_n_async,
    output logic [SLOTS-1:0] wait_act
);

    logic [SLOTS-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = wait_n_async;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '1;
            s2_q <= '1;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign wait_act[i] = ~s2_q[i];
        // R10: a released wait reaches the sequencer through both flops
        a_r10_sync_depth: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(wait_act[i]) |-> $past(s1_q[i]));
    end

endmodule

// File: rtl/pccard_strobe_dec.sv
module pccard_strobe_dec (
    input  logic active,
    input  logic is_io,
    input  logic write,
    output logic oe_n,
    output logic we_n,
    output logic iord_n,
    output logic iowr_n
);

    always_comb begin
        oe_n   = ~(active & ~is_io & ~write);
        we_n   = ~(active & ~is_io &  write);
        iord_n = ~(active &  is_io & ~write);
        iowr_n = ~(active &  is_io &  write);
    end

endmodule

// File: rtl/pccard_cycle_seq.sv
module pccard_cycle_seq
    import pccard_seq_pkg::*;
#(
    parameter int AW    = 26,
    parameter int EAW   = 20,
    parameter int DW    = 16,
    parameter int CW    = 4,
    parameter int SLOTS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [AW-1:0]           req_addr,
    input  logic                    req_is_io,
    input  logic                    req_write,
    input  logic [DW-1:0]           req_wdata,
    input  logic [1:0]              cfg_bus_size,
    input  logic [CW-1:0]           cfg_setup,
    input  logic [CW-1:0]           cfg_ext,
    input  logic [CW-1:0]           cfg_hold,
    input  logic                    cfg_rdy_en,
    input  logic [((SLOTS > 1) ? $clog2(SLOTS) : 1)-1:0] cfg_slot,
    input  logic [SLOTS-1:0]        card_wait_n,
    input  logic [DW-1:0]           card_din,
    output logic                    req_ready,
    output logic                    done,
    output logic                    rsp_err,
    output logic [DW-1:0]           rsp_rdata,
    output logic [EAW-1:0]          ext_addr,
    output logic                    uae,
    output logic [SLOTS-1:0]        card_sel_n,
    output logic                    oe_n,
    output logic                    we_n,
    output logic                    iord_n,
    output logic                    iowr_n,
    output logic [DW-1:0]           card_dout,
    output logic                    card_dout_en
);

    localparam int SLW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int UW  = AW - EAW;

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] addr;
        logic          is_io;
        logic          wr;
        logic [CW-1:0] setup;
        logic [CW-1:0] ext;
        logic [CW-1:0] hold;
        logic          rdy;
        logic [SLW-1:0] slot;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    logic [SLOTS-1:0] wait_act;
    logic          size_bad;
    logic          strobe_on;
    logic          addr_phase;

    pccard_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pccard_wait_sync #(.SLOTS(SLOTS)) u_wsync (
        .clk          (clk),
        .rst_n        (rst_n),
        .wait_n_async (card_wait_n),
        .wait_act     (wait_act)
    );

    assign size_bad = (cfg_bus_size != BUS_8) && (cfg_bus_size != BUS_16);

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.is_io = req_is_io;
                    r_d.wr    = req_write;
                    r_d.wdata = req_wdata;
                    r_d.setup = cfg_setup;
                    r_d.ext   = cfg_ext;
                    r_d.hold  = cfg_hold;
                    r_d.rdy   = cfg_rdy_en;
                    r_d.slot  = cfg_slot;
                    r_d.err   = size_bad;
                    r_d.st    = size_bad ? ST_DONE : ST_UPPER;
                end
            end
            ST_UPPER: begin
                r_d.st   = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = r_q.setup;
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    r_d.st   = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = r_q.ext;
                end
            end
            ST_STROBE: begin
                if (tmr_expired) begin
                    if (r_q.rdy) begin
                        r_d.st = ST_WAITRDY;
                    end else begin
                        r_d.st    = ST_HOLD;
                        r_d.rdata = card_din;
                        tmr_load  = 1'b1;
                        tmr_val   = r_q.hold;
                    end
                end
            end
            ST_WAITRDY: begin
                if (!wait_act[r_q.slot]) begin
                    r_d.st    = ST_HOLD;
                    r_d.rdata = card_din;
                    tmr_load  = 1'b1;
                    tmr_val   = r_q.hold;
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    r_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign strobe_on  = (r_q.st == ST_STROBE) || (r_q.st == ST_WAITRDY);
    assign addr_phase = (r_q.st == ST_SETUP) || strobe_on || (r_q.st == ST_HOLD);

    always_comb begin
        if (r_q.st == ST_UPPER) begin
            ext_addr = {{(EAW-UW){1'b0}}, r_q.addr[AW-1:EAW]};
        end else if (addr_phase) begin
            ext_addr = r_q.addr[EAW-1:0];
        end else begin
            ext_addr = '0;
        end
    end

    assign req_ready    = (r_q.st == ST_IDLE);
    assign uae          = (r_q.st == ST_UPPER);
    assign done         = (r_q.st == ST_DONE);
    assign rsp_err      = done && r_q.err;
    assign rsp_rdata    = r_q.rdata;
    assign card_dout    = r_q.wdata;
    assign card_dout_en = r_q.wr && addr_phase;

    for (genvar i = 0; i < SLOTS; i++) begin : g_sel
        assign card_sel_n[i] = ~((uae || addr_phase) && (r_q.slot == SLW'(i)));
    end

    pccard_strobe_dec u_dec (
        .active (strobe_on),
        .is_io  (r_q.is_io),
        .write  (r_q.wr),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .iord_n (iord_n),
        .iowr_n (iowr_n)
    );

    // R8: never more than one strobe low
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~oe_n, ~we_n, ~iord_n, ~iowr_n}));

    // R3: latch-enable phase is a single cycle with strobes quiet
    a_r3_uae_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        uae |-> (oe_n && we_n && iord_n && iowr_n));
    a_r3_uae_single: assert property (@(posedge clk) disable iff (!rst_n)
        uae |=> !uae);

    // R9: done is a single-cycle pulse followed by ready
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R5: an error completion follows acceptance directly
    a_r5_err_direct: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $past(req_ready));

    // R4: address holds still while the strobe is low
    a_r4_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_on && $past(strobe_on)) |-> $stable(ext_addr));

    // R2: the captured request does not change during a cycle
    a_r2_busy_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(r_q.addr));

endmodule

// File: tb/pccard_cycle_seq_bench.sv
module pccard_cycle_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [25:0] req_addr = '0;
    logic        req_is_io = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  cfg_bus_size = 2'b00;
    logic [3:0]  cfg_setup = '0;
    logic [3:0]  cfg_ext = '0;
    logic [3:0]  cfg_hold = '0;
    logic        cfg_rdy_en = 1'b0;
    logic [0:0]  cfg_slot = '0;
    logic [1:0]  card_wait_n = 2'b11;
    logic [15:0] card_din = '0;
    logic        req_ready, done, rsp_err, uae;
    logic [15:0] rsp_rdata, card_dout;
    logic [19:0] ext_addr;
    logic [1:0]  card_sel_n;
    logic        oe_n, we_n, iord_n, iowr_n, card_dout_en;

    int n_checks = 0;
    int n_fail   = 0;

    pccard_cycle_seq u_pccard_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_is_io(req_is_io), .req_write(req_write), .req_wdata(req_wdata),
        .cfg_bus_size(cfg_bus_size), .cfg_setup(cfg_setup), .cfg_ext(cfg_ext),
        .cfg_hold(cfg_hold), .cfg_rdy_en(cfg_rdy_en), .cfg_slot(cfg_slot),
        .card_wait_n(card_wait_n), .card_din(card_din), .req_ready(req_ready),
        .done(done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .ext_addr(ext_addr),
        .uae(uae), .card_sel_n(card_sel_n), .oe_n(oe_n), .we_n(we_n),
        .iord_n(iord_n), .iowr_n(iowr_n), .card_dout(card_dout),
        .card_dout_en(card_dout_en)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Runs one request and measures every phase from the pins.
    task automatic run_cycle(input string name, input logic [25:0] addr,
                             input logic io, input logic wr, input logic [1:0] bsz,
                             input int s, input int x, input int h,
                             input logic rdy, input int slot, input logic [1:0] wn,
                             input int rel_at, input bit scramble, input bit busy_req,
                             input int exp_str, input bit exp_err);
        int n_uae = 0, n_pre = 0, n_str = 0, n_post = 0;
        int bad_up = 0, bad_lo = 0, bad_type = 0, bad_sel = 0, bad_dout = 0;
        bit got_done = 0, got_err = 0;
        logic [15:0] rdv, wdv, got_rdata;
        logic [3:0] exp_strobe;
        logic [1:0] exp_sel;
        rdv = addr[15:0] ^ 16'hA55A;
        wdv = addr[15:0] ^ 16'h3C3C;
        exp_strobe = 4'b0001 << {io, wr};
        exp_sel = ~(2'b01 << slot);
        @(negedge clk);
        req_addr = addr; req_is_io = io; req_write = wr; req_wdata = wdv;
        cfg_bus_size = bsz; cfg_setup = 4'(s); cfg_ext = 4'(x); cfg_hold = 4'(h);
        cfg_rdy_en = rdy; cfg_slot = 1'(slot); card_wait_n = wn; card_din = rdv;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t < 200; t++) begin
            logic [3:0] lows;
            lows = {~iowr_n, ~iord_n, ~we_n, ~oe_n};
            if (done) begin
                got_done = 1; got_err = rsp_err; got_rdata = rsp_rdata;
                break;
            end
            if (card_sel_n != exp_sel) bad_sel++;
            if (uae) begin
                n_uae++;
                if (ext_addr != {14'd0, addr[25:20]} || lows != 4'b0) bad_up++;
                if (scramble) begin
                    cfg_setup = 4'hF; cfg_ext = 4'hF; cfg_hold = 4'hF;
                    cfg_rdy_en = ~rdy; cfg_slot = ~cfg_slot; cfg_bus_size = 2'b10;
                end
                if (busy_req) begin
                    req_valid = 1'b1; req_addr = ~addr;
                end
            end else begin
                if (ext_addr != addr[19:0]) bad_lo++;
                if (wr && (!card_dout_en || card_dout != wdv)) bad_dout++;
                if (!wr && card_dout_en) bad_dout++;
                if (lows != 4'b0) begin
                    n_str++;
                    if (lows != exp_strobe) bad_type++;
                    if (n_str == rel_at) card_wait_n = 2'b11;
                end else if (n_str == 0) begin
                    n_pre++;
                end else begin
                    n_post++;
                end
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(got_done, {name, " R9 done seen"}, got_done, 1);
        check(got_err == exp_err, {name, " R5 error flag"}, got_err, exp_err);
        if (exp_err) begin
            check(n_uae == 0 && n_str == 0 && n_pre == 0, {name, " R5 quiet bus"},
                  n_uae + n_str + n_pre, 0);
        end else begin
            check(n_uae == 1 && bad_up == 0, {name, " R3 upper phase"}, n_uae * 100 + bad_up, 100);
            check(n_pre == s + 1, {name, " R6 setup length"}, n_pre, s + 1);
            check(n_str == exp_str, {name, " R7 R10 R11 strobe length"}, n_str, exp_str);
            check(n_post == h + 1, {name, " R9 hold length"}, n_post, h + 1);
            check(bad_lo == 0, {name, " R4 byte address"}, bad_lo, 0);
            check(bad_type == 0, {name, " R8 strobe type"}, bad_type, 0);
            check(bad_sel == 0, {name, " R12 slot select"}, bad_sel, 0);
            check(bad_dout == 0, {name, " R13 write data"}, bad_dout, 0);
            if (!wr) check(got_rdata == rdv, {name, " R13 read data"}, got_rdata, rdv);
        end
        @(negedge clk);
        check(req_ready && !done, {name, " R9 ready after done"}, req_ready, 1);
        card_wait_n = 2'b11;
    endtask

    task automatic t_reset;
        // R1
        check(oe_n && we_n && iord_n && iowr_n, "R1 strobes high", {oe_n, we_n, iord_n, iowr_n}, 15);
        check(!uae && !done && !card_dout_en, "R1 outputs low", {uae, done, card_dout_en}, 0);
        check(req_ready && card_sel_n == 2'b11, "R1 ready and idle selects", {req_ready, card_sel_n}, 7);
    endtask

    task automatic t_mem_read_8;   // R3 R4 R6 R7 R8 R13
        run_cycle("mem_rd8", 26'h2ABCDE1, 0, 0, 2'b00, 1, 2, 1, 0, 0, 2'b11, -1, 0, 0, 3, 0);
    endtask

    task automatic t_mem_write_16; // R4 R8 R13 zero counts
        run_cycle("mem_wr16", 26'h3F00003, 0, 1, 2'b01, 0, 0, 0, 0, 1, 2'b11, -1, 0, 0, 1, 0);
    endtask

    task automatic t_io_rw;        // R8
        run_cycle("io_rd", 26'h0012345, 1, 0, 2'b01, 2, 1, 2, 0, 0, 2'b11, -1, 0, 0, 2, 0);
        run_cycle("io_wr", 26'h1C0FFEE, 1, 1, 2'b00, 0, 3, 0, 0, 1, 2'b11, -1, 0, 0, 4, 0);
    endtask

    task automatic t_wait_ignored; // R7: wait low but ready mode off
        run_cycle("rdy_off", 26'h0400001, 0, 0, 2'b01, 0, 2, 0, 0, 0, 2'b00, -1, 0, 0, 3, 0);
    endtask

    task automatic t_ready_wait;   // R10: release after 6 strobe cycles -> 8
        run_cycle("rdy_wait", 26'h0800010, 0, 0, 2'b01, 1, 2, 1, 1, 1, 2'b01, 6, 0, 0, 8, 0);
    endtask

    task automatic t_blanking;     // R11: wait low early, released inside extension
        run_cycle("blank_early", 26'h1000020, 1, 0, 2'b00, 0, 5, 0, 1, 0, 2'b10, 1, 0, 0, 7, 0);
        run_cycle("blank_idle", 26'h1000021, 0, 1, 2'b00, 0, 3, 0, 1, 0, 2'b11, -1, 0, 0, 5, 0);
    endtask

    task automatic t_slot_select;  // R12: other slot waiting has no effect
        run_cycle("slot_other", 26'h2000040, 0, 0, 2'b01, 0, 1, 0, 1, 0, 2'b01, -1, 0, 0, 3, 0);
    endtask

    task automatic t_illegal_size; // R5
        run_cycle("size32", 26'h0000100, 0, 0, 2'b10, 1, 1, 1, 0, 0, 2'b11, -1, 0, 0, 0, 1);
        run_cycle("size3", 26'h0000101, 1, 1, 2'b11, 0, 0, 0, 0, 1, 2'b11, -1, 0, 0, 0, 1);
    endtask

    task automatic t_busy_ignored; // R2
        run_cycle("busy_req", 26'h0A00200, 0, 0, 2'b01, 1, 1, 1, 0, 0, 2'b11, -1, 0, 1, 2, 0);
        for (int i = 0; i < 3; i++) begin
            check(!uae && req_ready, "R2 no cycle from busy request", uae, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_cfg_snapshot; // R14
        run_cycle("snapshot", 26'h1500300, 1, 1, 2'b01, 2, 1, 2, 0, 0, 2'b11, -1, 1, 0, 2, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_mem_read_8();
        t_mem_write_16();
        t_io_rw();
        t_wait_ignored();
        t_ready_wait();
        t_blanking();
        t_slot_select();
        t_illegal_size();
        t_busy_ignored();
        t_cfg_snapshot();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule